// File: doc/BRIEF.md
# Half-Duplex Collision Jam and Backoff Controller

This block runs beside a half-duplex Ethernet transmitter and decides what happens after a collision. The frame generator tells it when a frame is on the wire, whether preamble is still being sent, and how many bytes of the frame have gone out. When a collision is flagged, the controller drives an all-ones jam onto the transmit data path for a fixed number of bit times. If preamble is still going out, the jam waits until the preamble ends. Once the jam finishes, the controller classifies the collision.

An early collision leads to a retry. The controller picks a random number of slot times from a window that doubles with each attempt, then reports when that wait has ended. A late collision is never retried and is reported as an error. An early collision that would be the sixteenth attempt in a row gives up the frame with its own error. A frame that completes cleanly resets the attempt count.

All timing moves only on the bit-time tick. The random draw comes from an internal 16-bit LFSR.

Top module: `hd_collision_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `jam_active`, `jam_data`, `retry_request`, `backoff_done`, `late_collision_error` and `excessive_retry_error` are all zero.
- R2: When the block is idle and a ticked clock sees `tx_active` and `collision` high with `preamble_active` low, `jam_active` rises on that edge. It stays high for exactly JAM_BITS ticks (default 32), and `jam_data` is all ones while it is high and all zeros otherwise.
- R3: If `preamble_active` is high when the collision is taken, `jam_active` stays low until a ticked clock sees `preamble_active` low. The jam starts on that edge and then lasts JAM_BITS ticks.
- R4: A collision taken with `bytes_sent` below LATE_BYTES (default 64, so counts 0 to 63) that is not the sixteenth attempt raises `retry_request` for one clock, on the same edge where `jam_active` falls.
- R5: A collision taken with `bytes_sent` at or above LATE_BYTES raises `late_collision_error` for one clock when the jam ends. It raises neither `retry_request` nor `backoff_done`, and it clears the attempt count.
- R6: After `retry_request` for the n-th consecutive attempt, `backoff_done` pulses for one clock exactly r*SLOT_BITS+1 ticks later (SLOT_BITS defaults to 512), with 0 <= r < 2^min(n,10).
- R7: The sixteenth consecutive early collision raises `excessive_retry_error` for one clock when its jam ends, with no `retry_request`. The attempt count is cleared, so the next collision is treated as attempt 1.
- R8: A ticked clock in idle that sees `frame_done` high clears the attempt count.
- R9: A collision is ignored while a jam or a backoff is in progress, and also whenever `tx_active` is low. Jam length and the outcome pulses are unchanged, and no new jam starts.
- R10: No state moves on a clock where `bit_tick` is low. A collision seen only on unticked clocks starts no jam, and unticked clocks do not count toward the jam length.

Ports are listed in declaration order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-clock enable per bit time |
| tx_active | input | 1 | A frame is being transmitted |
| collision | input | 1 | Collision detected on the medium |
| preamble_active | input | 1 | Preamble is still being sent |
| bytes_sent | input | BYTE_W | Bytes of the current frame already sent |
| frame_done | input | 1 | Current frame completed without collision |
| jam_active | output | 1 | Jam is being driven |
| jam_data | output | DATA_W | Transmit data during jam (all ones) |
| retry_request | output | 1 | One-clock pulse: a retry has been scheduled |
| backoff_done | output | 1 | One-clock pulse: backoff interval elapsed |
| late_collision_error | output | 1 | One-clock pulse: frame dropped after a late collision |
| excessive_retry_error | output | 1 | One-clock pulse: frame dropped after too many attempts |

## Verification
The hardest state to reach is the sixteenth consecutive early collision. Getting there takes fifteen full jam-and-backoff rounds, and the wait grows to as many as 1023 slots once the exponent saturates. The bench shrinks the slot to three bit times and runs a long chain of early collisions. It first clears the count part-way through with `frame_done`, so the error must appear exactly on the sixteenth collision after the clear and not earlier. The backoff length is random, so each wait is checked against its window and its slot granularity, not against a fixed value.

// File: rtl/hd_collision_ctrl.sv
module hd_collision_ctrl #(
  parameter int DATA_W        = 4,
  parameter int BYTE_W        = 11,
  parameter int JAM_BITS      = 32,
  parameter int SLOT_BITS     = 512,
  parameter int LATE_BYTES    = 64,
  parameter int MAX_ATTEMPTS  = 16,
  parameter int BACKOFF_LIMIT = 10,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_active,
  input  logic              collision,
  input  logic              preamble_active,
  input  logic [BYTE_W-1:0] bytes_sent,
  input  logic              frame_done,
  output logic              jam_active,
  output logic [DATA_W-1:0] jam_data,
  output logic              retry_request,
  output logic              backoff_done,
  output logic              late_collision_error,
  output logic              excessive_retry_error
);
  localparam int JAM_CW  = $clog2(JAM_BITS);
  localparam int SLOT_CW = $clog2(SLOT_BITS);
  localparam int ATT_W   = $clog2(MAX_ATTEMPTS + 1);
  localparam int R_W     = BACKOFF_LIMIT;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_JAM, S_WAIT} st_t;

  st_t               st;
  logic [JAM_CW-1:0] jam_cnt;
  logic [SLOT_CW-1:0] slot_cnt;
  logic [R_W-1:0]    slots_left;
  logic [ATT_W-1:0]  attempts;
  logic              late_q;
  logic [15:0]       lfsr;

  logic [ATT_W-1:0]  att_inc;
  logic [ATT_W-1:0]  win_exp;
  logic [R_W-1:0]    win_mask;
  logic              give_up;
  logic              jam_last;

  assign att_inc  = attempts + ATT_W'(1);
  assign give_up  = (att_inc == ATT_W'(MAX_ATTEMPTS));
  assign win_exp  = (att_inc > ATT_W'(BACKOFF_LIMIT)) ? ATT_W'(BACKOFF_LIMIT) : att_inc;
  assign win_mask = R_W'((32'd1 << win_exp) - 32'd1);
  assign jam_last = (jam_cnt == JAM_CW'(JAM_BITS - 1));

  assign jam_active = (st == S_JAM);
  assign jam_data   = {DATA_W{jam_active}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st                    <= S_IDLE;
      jam_cnt               <= '0;
      slot_cnt              <= '0;
      slots_left            <= '0;
      attempts              <= '0;
      late_q                <= 1'b0;
      lfsr                  <= LFSR_SEED;
      retry_request         <= 1'b0;
      backoff_done          <= 1'b0;
      late_collision_error  <= 1'b0;
      excessive_retry_error <= 1'b0;
    end else begin
      lfsr                  <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      retry_request         <= 1'b0;
      backoff_done          <= 1'b0;
      late_collision_error  <= 1'b0;
      excessive_retry_error <= 1'b0;
      if (bit_tick) begin
        case (st)
          S_IDLE: begin
            if (tx_active && collision) begin
              late_q  <= (bytes_sent >= BYTE_W'(LATE_BYTES));
              jam_cnt <= '0;
              st      <= preamble_active ? S_HOLD : S_JAM;
            end else if (frame_done) begin
              attempts <= '0;
            end
          end
          S_HOLD: begin
            if (!preamble_active) st <= S_JAM;
          end
          S_JAM: begin
            if (!jam_last) begin
              jam_cnt <= jam_cnt + JAM_CW'(1);
            end else if (late_q) begin
              late_collision_error <= 1'b1;
              attempts             <= '0;
              st                   <= S_IDLE;
            end else if (give_up) begin
              excessive_retry_error <= 1'b1;
              attempts              <= '0;
              st                    <= S_IDLE;
            end else begin
              retry_request <= 1'b1;
              attempts      <= att_inc;
              slots_left    <= lfsr[R_W-1:0] & win_mask;
              slot_cnt      <= '0;
              st            <= S_WAIT;
            end
          end
          S_WAIT: begin
            if (slots_left == '0) begin
              backoff_done <= 1'b1;
              st           <= S_IDLE;
            end else if (slot_cnt == SLOT_CW'(SLOT_BITS - 1)) begin
              slot_cnt   <= '0;
              slots_left <= slots_left - R_W'(1);
            end else begin
              slot_cnt <= slot_cnt + SLOT_CW'(1);
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hd_coll_checker.sv
module hd_coll_checker #(
  parameter int JAM_BITS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic preamble_active,
  input logic jam_active,
  input logic retry_request,
  input logic backoff_done,
  input logic late_collision_error,
  input logic excessive_retry_error
);
  int jam_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n) jam_ticks <= 0;
    else if (jam_active) jam_ticks <= jam_ticks + (bit_tick ? 1 : 0);
    else jam_ticks <= 0;
  end

  assert_jam_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jam_active) |-> jam_ticks == JAM_BITS);

  assert_jam_after_preamble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_active) |-> $past(!preamble_active));

  assert_retry_at_jam_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retry_request |-> ($past(jam_active) && !jam_active));

  assert_late_at_jam_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    late_collision_error |-> ($past(jam_active) && !jam_active));

  assert_backoff_outside_jam_R6: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_done |-> (!jam_active && $past(!jam_active)));

  assert_excess_at_jam_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    excessive_retry_error |-> ($past(jam_active) && !jam_active));

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retry_request, late_collision_error, excessive_retry_error, backoff_done}));

  assert_jam_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_active) |-> $past(bit_tick));
endmodule

bind hd_collision_ctrl hd_coll_checker #(.JAM_BITS(JAM_BITS)) u_chk (
  .clk                   (clk),
  .rst_n                 (rst_n),
  .bit_tick              (bit_tick),
  .preamble_active       (preamble_active),
  .jam_active            (jam_active),
  .retry_request         (retry_request),
  .backoff_done          (backoff_done),
  .late_collision_error  (late_collision_error),
  .excessive_retry_error (excessive_retry_error)
);

// File: tb/sim_hd_collision_ctrl.sv
module sim_hd_collision_ctrl;
  localparam int DATA_W = 4;
  localparam int BYTE_W = 11;
  localparam int JAM    = 32;
  localparam int SLOT   = 3;
  localparam int NVEC   = 7;
  // columns: preamble, preamble_len, bytes_sent, noisy, alt_tick, expected (0 retry, 1 late)
  localparam int VEC [NVEC][6] = '{
    '{0, 0,  10, 0, 0, 0},
    '{0, 0,  63, 0, 0, 0},
    '{0, 0,  64, 0, 0, 1},
    '{1, 5,   0, 0, 0, 0},
    '{1, 1,   0, 0, 1, 0},
    '{0, 0, 300, 1, 0, 1},
    '{0, 0,  20, 1, 1, 0}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic bit_tick = 0, tx_active = 0, collision = 0, preamble_active = 0, frame_done = 0;
  logic [BYTE_W-1:0] bytes_sent = '0;
  logic jam_active, retry_request, backoff_done, late_collision_error, excessive_retry_error;
  logic [DATA_W-1:0] jam_data;

  int tests = 0, fails = 0, n_att = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hd_collision_ctrl #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .JAM_BITS(JAM), .SLOT_BITS(SLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_active(tx_active),
    .collision(collision), .preamble_active(preamble_active), .bytes_sent(bytes_sent),
    .frame_done(frame_done), .jam_active(jam_active), .jam_data(jam_data),
    .retry_request(retry_request), .backoff_done(backoff_done),
    .late_collision_error(late_collision_error), .excessive_retry_error(excessive_retry_error));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // exp_out: 0 retry, 1 late, 2 excessive
  task automatic episode(input bit pre, input int pre_len, input int bytes,
                         input bit noisy, input bit alt, input int exp_out);
    int ticks, d, lim, n;
    n = n_att + 1;
    @(negedge clk);
    tx_active = 1; collision = 1; preamble_active = pre; bit_tick = 1;
    bytes_sent = BYTE_W'(bytes);
    @(negedge clk);
    tx_active = 0; collision = noisy;
    if (pre) begin
      for (int i = 0; i < pre_len; i++) begin
        chk(jam_active == 0, "R3 jam held during preamble", int'(jam_active), 0);
        @(negedge clk);
      end
      chk(jam_active == 0, "R3 jam held during preamble", int'(jam_active), 0);
      preamble_active = 0;
      @(negedge clk);
    end
    chk(jam_active == 1, "R2 jam started", int'(jam_active), 1);
    chk(jam_data == '1, "R2 jam data all ones", int'(jam_data), (1 << DATA_W) - 1);
    ticks = 0;
    for (int g = 0; g < 1000 && jam_active; g++) begin
      bit_tick = alt ? ~bit_tick : 1'b1;
      if (bit_tick) ticks++;
      @(negedge clk);
    end
    bit_tick = 1;
    chk(ticks == JAM, alt ? "R10 jam ticks with sparse tick" : "R2 jam length", ticks, JAM);
    chk(jam_data == '0, "R2 jam data idle", int'(jam_data), 0);
    chk(retry_request == (exp_out == 0), "R4 retry pulse", int'(retry_request), int'(exp_out == 0));
    chk(late_collision_error == (exp_out == 1), "R5 late error pulse", int'(late_collision_error), int'(exp_out == 1));
    chk(excessive_retry_error == (exp_out == 2), "R7 excessive pulse", int'(excessive_retry_error), int'(exp_out == 2));
    if (exp_out == 0) begin
      d = 0;
      for (int g = 0; g < 5000; g++) begin
        @(negedge clk);
        d++;
        if (backoff_done) break;
      end
      lim = 1 << ((n > 10) ? 10 : n);
      chk(backoff_done == 1, "R6 backoff done seen", int'(backoff_done), 1);
      chk((d - 1) % SLOT == 0, "R6 backoff slot granularity", d - 1, ((d - 1) / SLOT) * SLOT);
      chk((d - 1) / SLOT < lim, "R6 backoff window", (d - 1) / SLOT, lim - 1);
      n_att = n;
      @(negedge clk);
      chk(backoff_done == 0, "R6 backoff pulse width", int'(backoff_done), 0);
    end else begin
      n_att = 0;
      @(negedge clk);
      chk(!late_collision_error && !excessive_retry_error && !backoff_done,
          "R5 no follow-up pulse", int'(late_collision_error | excessive_retry_error | backoff_done), 0);
    end
    if (noisy) begin
      repeat (3) @(negedge clk);
      chk(jam_active == 0, "R9 collision without tx ignored", int'(jam_active), 0);
    end
    collision = 0;
  endtask

  task automatic end_frame();
    @(negedge clk);
    frame_done = 1; bit_tick = 1;
    @(negedge clk);
    frame_done = 0;
    n_att = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({jam_active, jam_data, retry_request, backoff_done, late_collision_error, excessive_retry_error} == '0,
        "R1 outputs in reset", int'(jam_active), 0);
    rst_n = 1;
    @(negedge clk);
    chk({jam_active, retry_request, backoff_done, late_collision_error, excessive_retry_error} == '0,
        "R1 outputs after reset", int'(jam_active), 0);

    // R10: collision seen only without tick
    tx_active = 1; collision = 1; bit_tick = 0;
    repeat (4) begin
      @(negedge clk);
      chk(jam_active == 0, "R10 no jam without tick", int'(jam_active), 0);
    end
    tx_active = 0; collision = 0;

    for (int v = 0; v < NVEC; v++)
      episode(VEC[v][0] != 0, VEC[v][1], VEC[v][2], VEC[v][3] != 0, VEC[v][4] != 0, VEC[v][5]);
    end_frame();

    // R8: attempt count cleared by frame_done, then R7 excessive on 16th
    repeat (3) episode(0, 0, 5, 0, 0, 0);
    end_frame();
    for (int k = 1; k <= 16; k++)
      episode(0, 0, 5, 0, 0, (k == 16) ? 2 : 0);
    // R7: counter cleared after excessive error, next attempt window is 2 slots
    episode(0, 0, 5, 0, 0, 0);
    // R5: late collision clears count, next attempt is attempt 1
    episode(0, 0, 100, 0, 0, 1);
    episode(0, 0, 5, 0, 0, 0);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule